// File: doc/BRIEF.md
# Per-Lane Receive Reference Voltage Search

This block tunes the receive reference-voltage index of every byte lane of a memory interface. After a start pulse it loads a per-lane state from a prior eye-width figure. It then runs a fixed number of search iterations. In each iteration it asks an external measurement engine for three valid-window readings, keeps a running average per lane, and compares that average with the best window seen so far. From the result it moves each lane's 3-bit index.

The search first climbs in steps of three. It then walks back in steps of one towards a floor value and settles each lane on its own. The comparison allows a margin, so a slightly smaller window still counts as "not worse".

Every index change is written into the lane's PHY register by a read-modify-write. Only the low nibble is replaced, and it carries a remapped code for the index. When the search ends, the block raises `done` and presents the last index it wrote for each lane.

Top module: `vref_tuner`

## Requirements
- R1: A lane whose prior width is above 12 is marked settled at start. It is never written and reports index 0. A lane whose prior width is 12 or less is tuned.
- R2: At start, every tuned lane begins in the coarse state at index 0. Before the first measurement request, each tuned lane is written once with the code for index 0.
- R3: Each register write replaces bits [3:0] with code = (index + 1) mod 8, with bit 3 zero. Bits above [3:0] keep the value read from that lane in the access just before.
- R4: Each iteration takes three measurements. For the k-th one (k = 1..3), every unsettled lane sets avg = (avg*(k-1) + 1000*width) / k, truncated. Settled lanes keep their values.
- R5: A result is not worse when avg + 200 >= best. In that case best becomes max(avg, best).
- R6: Coarse state, not worse: at index 7 the lane settles and writes 7. Otherwise the index becomes min(index+3, 7). Floor and last index take the same value, and reaching 7 moves the lane to the fine state.
- R7: Coarse state, worse: the lane moves to fine with floor = index-3, best = avg, last = index, and the new index = index-1. All of this is 3-bit wrapping arithmetic.
- R8: Fine state, not worse: last = index. If index-1 equals the floor, the index decrements and the lane settles. Else if index equals the floor, the lane settles. Else the index decrements.
- R9: Fine state, worse: the last index is written and the lane settles.
- R10: The run lasts while the count of lanes settled by the search is at most the lane count and fewer than MAX_ITER iterations have run. After each iteration, exactly the lanes that were unsettled at its start are written.
- R11: At the end, `done` rises and stays high with `final_idx` stable until the next start. `final_idx` holds the last index written to each lane.
- R12: Measurement requests, register reads and register writes never overlap. A read is a one-cycle pulse, and `phy_lane` is always a valid lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Starts a run; sampled while idle or done |
| prior_win | input | LANES*PW_W | Prior eye width per lane, sampled with start |
| meas_req | output | 1 | Measurement wanted; held until the third ack |
| meas_ack | input | 1 | One-cycle pulse ending one measurement |
| meas_width | input | LANES*WIN_W | Window width per lane, valid with meas_ack |
| phy_rd | output | 1 | One-cycle register read request |
| phy_wr | output | 1 | One-cycle register write |
| phy_lane | output | LANE_W | Lane addressed by the read or write |
| phy_rvalid | input | 1 | Read data valid pulse |
| phy_rdata | input | REG_W | Read data |
| phy_wdata | output | REG_W | Write data |
| done | output | 1 | Search finished |
| final_idx | output | LANES*3 | Last written index per lane |

## Verification
The assertions assume two things about the environment. First, `phy_rvalid` arrives at least one cycle after a read pulse. Second, read data is only needed on the cycle of that pulse, which lets the write check compare upper bits against the value seen one cycle earlier. The bench responders insert a random 1 to 3 cycle latency before each read response and each measurement acknowledge, and they never pulse an acknowledge without a pending request. Window widths mix random values with directed climbing, falling and near-margin patterns. Prior widths straddle the threshold at 12 and 13.

// File: rtl/vref_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the per-lane Vref search.
// Assumes a 3-bit index space and a 4-bit register code field at bits [3:0].
package vref_pkg;
    localparam int IDX_W       = 3;
    localparam int CODE_W      = 4;
    localparam int IDX_MAX     = 7;
    localparam int COARSE_STEP = 3;
    localparam int FINE_STEP   = 1;
    localparam int HYST        = 200;
    localparam int SCALE       = 1000;
    localparam int REPS        = 3;

    typedef enum logic [1:0] {LS_COARSE, LS_FINE, LS_DONE} lane_st_e;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_SCAN, SQ_RD, SQ_RWAIT, SQ_WR, SQ_MEAS, SQ_STEP, SQ_DONE
    } seq_st_e;

    // Non-linear remap: index i is written as (i+1) mod 8.
    function automatic logic [CODE_W-1:0] code_of(input logic [IDX_W-1:0] idx);
        logic [IDX_W-1:0] c;
        c = idx + IDX_W'(1);
        return {1'b0, c};
    endfunction
endpackage

// File: rtl/vref_lane.sv
`timescale 1ns/1ps
// One lane of the search: keeps the running window average, the best window,
// the index, floor and last index, and applies the coarse/fine decision rules.
// Assumes init, avg_en and step_en are mutually exclusive single-cycle pulses.
module vref_lane import vref_pkg::*; #(
    parameter int WIN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             skip,
    input  logic             avg_en,
    input  logic [1:0]       rep,
    input  logic [WIN_W-1:0] width,
    input  logic             step_en,
    output logic             conv,
    output logic             conv_evt,
    output logic [IDX_W-1:0] wr_idx
);
    localparam int AVG_W = $clog2(SCALE * ((1 << WIN_W) - 1) + 1);
    localparam int SUM_W = AVG_W + 2;

    lane_st_e         st, st_n;
    logic [AVG_W-1:0] avg, best, best_n, avg_new, win_max;
    logic [IDX_W-1:0] cur, lim, last, cur_n, lim_n, last_n, wr_n;
    logic [SUM_W-1:0] prod, acc;
    logic [IDX_W:0]   climb;
    logic [IDX_W-1:0] climb_sat;
    logic             not_worse;

    // Running average of the k-th measurement of an iteration.
    always_comb begin
        prod = SUM_W'(width) * SUM_W'(SCALE);
        case (rep)
            2'd2:    acc = SUM_W'(avg) + prod;
            2'd3:    acc = (SUM_W'(avg) << 1) + prod;
            default: acc = prod;
        endcase
        case (rep)
            2'd2:    avg_new = AVG_W'(acc >> 1);
            2'd3:    avg_new = AVG_W'(acc / SUM_W'(3));
            default: avg_new = AVG_W'(acc);
        endcase
    end

    // Decision rules applied once per iteration.
    always_comb begin
        not_worse = ({1'b0, avg} + (AVG_W+1)'(HYST)) >= {1'b0, best};
        win_max   = (avg > best) ? avg : best;
        climb     = {1'b0, cur} + (IDX_W+1)'(COARSE_STEP);
        climb_sat = (climb > (IDX_W+1)'(IDX_MAX)) ? IDX_W'(IDX_MAX) : climb[IDX_W-1:0];
        st_n = st; best_n = best; cur_n = cur; lim_n = lim; last_n = last; wr_n = wr_idx;
        case (st)
            LS_COARSE: begin
                if (not_worse) begin
                    best_n = win_max;
                    if (cur == IDX_W'(IDX_MAX)) begin
                        st_n = LS_DONE;
                        wr_n = cur;
                    end else begin
                        cur_n = climb_sat; lim_n = climb_sat; last_n = climb_sat;
                        wr_n  = climb_sat;
                        if (climb_sat == IDX_W'(IDX_MAX)) st_n = LS_FINE;
                    end
                end else begin
                    st_n   = LS_FINE;
                    lim_n  = cur - IDX_W'(COARSE_STEP);
                    best_n = avg;
                    last_n = cur;
                    cur_n  = cur - IDX_W'(FINE_STEP);
                    wr_n   = cur - IDX_W'(FINE_STEP);
                end
            end
            LS_FINE: begin
                if (not_worse) begin
                    best_n = win_max;
                    last_n = cur;
                    if (cur - IDX_W'(FINE_STEP) == lim) begin
                        cur_n = cur - IDX_W'(FINE_STEP);
                        st_n  = LS_DONE;
                    end else if (cur == lim) begin
                        st_n  = LS_DONE;
                    end else begin
                        cur_n = cur - IDX_W'(FINE_STEP);
                    end
                    wr_n = cur_n;
                end else begin
                    wr_n = last;
                    st_n = LS_DONE;
                end
            end
            default: ;
        endcase
    end

    assign conv     = (st == LS_DONE);
    assign conv_evt = step_en && (st != LS_DONE) && (st_n == LS_DONE);

    // Lane state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= LS_DONE; avg <= '0; best <= '0;
            cur <= '0; lim <= '0; last <= '0; wr_idx <= '0;
        end else if (init) begin
            st <= skip ? LS_DONE : LS_COARSE; avg <= '0; best <= '0;
            cur <= '0; lim <= '0; last <= '0; wr_idx <= '0;
        end else if (avg_en && st != LS_DONE) begin
            avg <= avg_new;
        end else if (step_en && st != LS_DONE) begin
            st <= st_n; best <= best_n; cur <= cur_n;
            lim <= lim_n; last <= last_n; wr_idx <= wr_n;
        end
    end
endmodule

// File: rtl/vref_seq.sv
`timescale 1ns/1ps
// Run sequencer: issues the measurement requests, counts iterations and
// settled lanes, and performs the per-lane read-modify-write of the code.
// Assumes phy_rvalid comes at least one cycle after a phy_rd pulse.
module vref_seq import vref_pkg::*; #(
    parameter int LANES    = 4,
    parameter int REG_W    = 16,
    parameter int MAX_ITER = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [LANES-1:0]        skip_vec,
    input  logic [LANES-1:0]        conv_vec,
    input  logic [LANES-1:0]        conv_evt_vec,
    input  logic [LANES*IDX_W-1:0]  wr_idx_flat,
    input  logic                    meas_ack,
    input  logic                    phy_rvalid,
    input  logic [REG_W-1:0]        phy_rdata,
    output logic                    lane_init,
    output logic                    avg_en,
    output logic [1:0]              rep,
    output logic                    step_en,
    output logic                    meas_req,
    output logic                    phy_rd,
    output logic                    phy_wr,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] phy_lane,
    output logic [REG_W-1:0]        phy_wdata,
    output logic                    done
);
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int ITER_W = $clog2(MAX_ITER + 1);
    localparam int CNT_W  = $clog2(LANES + 2);

    seq_st_e           st, loop_next;
    logic [LANES-1:0]  wmask;
    logic [LANE_W-1:0] ptr;
    logic [ITER_W-1:0] iter;
    logic [CNT_W-1:0]  cnt;
    logic [REG_W-1:0]  rdata_q;
    logic [1:0]        rep_q;
    logic              last_ptr;

    // Decode of outputs and the loop-continue decision.
    always_comb begin
        last_ptr  = (ptr == LANE_W'(LANES - 1));
        loop_next = (cnt <= CNT_W'(LANES) && iter < ITER_W'(MAX_ITER)) ? SQ_MEAS : SQ_DONE;
        lane_init = (st == SQ_IDLE || st == SQ_DONE) && start;
        avg_en    = (st == SQ_MEAS) && meas_ack;
        step_en   = (st == SQ_STEP);
        meas_req  = (st == SQ_MEAS);
        phy_rd    = (st == SQ_RD);
        phy_wr    = (st == SQ_WR);
        done      = (st == SQ_DONE);
        rep       = rep_q;
        phy_lane  = ptr;
        phy_wdata = {rdata_q[REG_W-1:CODE_W], code_of(wr_idx_flat[ptr*IDX_W +: IDX_W])};
    end

    // Sequencer state and counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SQ_IDLE; wmask <= '0; ptr <= '0; iter <= '0;
            cnt <= '0; rdata_q <= '0; rep_q <= 2'd1;
        end else begin
            case (st)
                SQ_IDLE, SQ_DONE: if (start) begin
                    wmask <= ~skip_vec; ptr <= '0; iter <= '0;
                    cnt <= '0; rep_q <= 2'd1; st <= SQ_SCAN;
                end
                SQ_SCAN: begin
                    if (wmask[ptr])    st  <= SQ_RD;
                    else if (last_ptr) st  <= loop_next;
                    else               ptr <= ptr + LANE_W'(1);
                end
                SQ_RD:    st <= SQ_RWAIT;
                SQ_RWAIT: if (phy_rvalid) begin
                    rdata_q <= phy_rdata;
                    st      <= SQ_WR;
                end
                SQ_WR: begin
                    if (last_ptr) st <= loop_next;
                    else begin
                        ptr <= ptr + LANE_W'(1);
                        st  <= SQ_SCAN;
                    end
                end
                SQ_MEAS: if (meas_ack) begin
                    if (rep_q == 2'(REPS)) st <= SQ_STEP;
                    else                   rep_q <= rep_q + 2'd1;
                end
                SQ_STEP: begin
                    wmask <= ~conv_vec;
                    cnt   <= cnt + CNT_W'($countones(conv_evt_vec));
                    iter  <= iter + ITER_W'(1);
                    ptr   <= '0;
                    rep_q <= 2'd1;
                    st    <= SQ_SCAN;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vref_tuner.sv
`timescale 1ns/1ps
// Top of the per-lane Vref search: one vref_lane per byte lane plus the
// shared sequencer. Assumes prior_win is valid in the cycle start is sampled.
module vref_tuner import vref_pkg::*; #(
    parameter int LANES    = 4,
    parameter int WIN_W    = 5,
    parameter int PW_W     = 8,
    parameter int SKIP_TH  = 12,
    parameter int REG_W    = 16,
    parameter int MAX_ITER = 10
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [LANES*PW_W-1:0]  prior_win,
    output logic                   meas_req,
    input  logic                   meas_ack,
    input  logic [LANES*WIN_W-1:0] meas_width,
    output logic                   phy_rd,
    output logic                   phy_wr,
    output logic [((LANES > 1) ? $clog2(LANES) : 1)-1:0] phy_lane,
    input  logic                   phy_rvalid,
    input  logic [REG_W-1:0]       phy_rdata,
    output logic [REG_W-1:0]       phy_wdata,
    output logic                   done,
    output logic [LANES*3-1:0]     final_idx
);
    logic [LANES-1:0]       skip_vec, conv_vec, conv_evt_vec;
    logic [LANES*IDX_W-1:0] wr_idx_flat;
    logic                   lane_init, avg_en, step_en;
    logic [1:0]             rep;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign skip_vec[i] = prior_win[i*PW_W +: PW_W] > PW_W'(SKIP_TH);
        vref_lane #(.WIN_W(WIN_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .init(lane_init), .skip(skip_vec[i]),
            .avg_en(avg_en), .rep(rep), .width(meas_width[i*WIN_W +: WIN_W]),
            .step_en(step_en), .conv(conv_vec[i]), .conv_evt(conv_evt_vec[i]),
            .wr_idx(wr_idx_flat[i*IDX_W +: IDX_W])
        );
    end

    vref_seq #(.LANES(LANES), .REG_W(REG_W), .MAX_ITER(MAX_ITER)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .skip_vec(skip_vec),
        .conv_vec(conv_vec), .conv_evt_vec(conv_evt_vec), .wr_idx_flat(wr_idx_flat),
        .meas_ack(meas_ack), .phy_rvalid(phy_rvalid), .phy_rdata(phy_rdata),
        .lane_init(lane_init), .avg_en(avg_en), .rep(rep), .step_en(step_en),
        .meas_req(meas_req), .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_lane(phy_lane),
        .phy_wdata(phy_wdata), .done(done)
    );

    assign final_idx = wr_idx_flat;
endmodule

// File: rtl/vref_tuner_chk.sv
`timescale 1ns/1ps
// Port-level checks for vref_tuner, attached by bind.
// Assumes read data is returned at least one cycle after the read pulse.
module vref_tuner_chk #(
    parameter int LANES  = 4,
    parameter int REG_W  = 16,
    parameter int LANE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               meas_req,
    input logic               phy_rd,
    input logic               phy_wr,
    input logic               phy_rvalid,
    input logic [LANE_W-1:0]  phy_lane,
    input logic [REG_W-1:0]   phy_rdata,
    input logic [REG_W-1:0]   phy_wdata,
    input logic               done,
    input logic [LANES*3-1:0] final_idx
);
    // R12
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({meas_req, phy_rd, phy_wr}) <= 1);
    // R12
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_rd |=> !phy_rd);
    // R12
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rd || phy_wr) |-> (int'(phy_lane) < LANES));
    // R3
    keep_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_wr |-> ($past(phy_rvalid) && phy_wdata[REG_W-1:4] == $past(phy_rdata[REG_W-1:4])));
    // R3
    code_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phy_wr |-> !phy_wdata[3]);
    // R11
    hold_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(final_idx));
endmodule

bind vref_tuner vref_tuner_chk #(
    .LANES(LANES), .REG_W(REG_W), .LANE_W((LANES > 1) ? $clog2(LANES) : 1)
) u_chk (
    .clk(clk), .rst_n(rst_n), .meas_req(meas_req), .phy_rd(phy_rd),
    .phy_wr(phy_wr), .phy_rvalid(phy_rvalid), .phy_lane(phy_lane),
    .phy_rdata(phy_rdata), .phy_wdata(phy_wdata), .done(done),
    .final_idx(final_idx)
);

// File: tb/vref_tuner_test.sv
`timescale 1ns/1ps
// Bench: random and directed window patterns, a bench-side search model,
// and responders for the measurement and PHY register interfaces.
module vref_tuner_test;
    localparam int LANES = 4;
    localparam int MAXIT = 10;

    logic              clk = 0, rst_n = 0, start = 0;
    logic [LANES*8-1:0] prior_win = '0;
    logic              meas_req, meas_ack = 0;
    logic [LANES*5-1:0] meas_width = '0;
    logic              phy_rd, phy_wr, phy_rvalid = 0;
    logic [1:0]        phy_lane;
    logic [15:0]       phy_rdata = '0, phy_wdata;
    logic              done;
    logic [LANES*3-1:0] final_idx;

    vref_tuner uut (
        .clk(clk), .rst_n(rst_n), .start(start), .prior_win(prior_win),
        .meas_req(meas_req), .meas_ack(meas_ack), .meas_width(meas_width),
        .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_lane(phy_lane),
        .phy_rvalid(phy_rvalid), .phy_rdata(phy_rdata), .phy_wdata(phy_wdata),
        .done(done), .final_idx(final_idx)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0;
    int mode = 0;
    logic [15:0] regs [LANES], regs0 [LANES];
    int m_st[LANES], m_avg[LANES], m_best[LANES], m_cur[LANES], m_lim[LANES];
    int m_last[LANES], m_wr[LANES], m_act[LANES], m_wexp[LANES], m_wcnt[LANES];
    int m_k = 1, m_cnt = 0, m_iter = 0, m_meas = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int code_of(input int idx);
        return (idx + 1) & 7;
    endfunction

    function automatic int pick_w(input int md, input int l, input int it);
        int v;
        case (md)
            1: return 20 + l;
            2: begin v = 30 - (3 + l) * it; return (v < 0) ? 0 : v; end
            3: return 10 + int'($urandom % 3);
            default: return int'($urandom % 32);
        endcase
    endfunction

    // Model of one iteration decision (R5..R10).
    task automatic model_step();
        bit nw;
        for (int l = 0; l < LANES; l++) begin
            if (m_st[l] == 2) begin m_act[l] = 0; continue; end
            m_act[l] = 1; m_wexp[l]++;
            nw = (m_avg[l] + 200 >= m_best[l]);
            if (m_st[l] == 0) begin
                if (nw) begin
                    m_best[l] = (m_avg[l] > m_best[l]) ? m_avg[l] : m_best[l];
                    if (m_cur[l] == 7) begin m_st[l] = 2; m_cnt++; m_wr[l] = 7; end
                    else begin
                        m_cur[l] = (m_cur[l] + 3 > 7) ? 7 : m_cur[l] + 3;
                        m_lim[l] = m_cur[l]; m_last[l] = m_cur[l]; m_wr[l] = m_cur[l];
                        if (m_cur[l] == 7) m_st[l] = 1;
                    end
                end else begin
                    m_st[l] = 1; m_lim[l] = (m_cur[l] - 3) & 7; m_best[l] = m_avg[l];
                    m_last[l] = m_cur[l]; m_cur[l] = (m_cur[l] - 1) & 7; m_wr[l] = m_cur[l];
                end
            end else begin
                if (nw) begin
                    m_best[l] = (m_avg[l] > m_best[l]) ? m_avg[l] : m_best[l];
                    m_last[l] = m_cur[l];
                    if (((m_cur[l] - 1) & 7) == m_lim[l]) begin
                        m_cur[l] = (m_cur[l] - 1) & 7; m_st[l] = 2; m_cnt++;
                    end else if (m_cur[l] == m_lim[l]) begin
                        m_st[l] = 2; m_cnt++;
                    end else m_cur[l] = (m_cur[l] - 1) & 7;
                    m_wr[l] = m_cur[l];
                end else begin
                    m_wr[l] = m_last[l]; m_st[l] = 2; m_cnt++;
                end
            end
        end
        m_iter++;
    endtask

    // Measurement responder with random latency (R4).
    initial begin
        forever begin
            @(negedge clk);
            meas_ack = 0;
            if (meas_req && rst_n) begin
                repeat (1 + $urandom % 3) @(negedge clk);
                for (int l = 0; l < LANES; l++) begin
                    int w;
                    w = pick_w(mode, l, m_iter);
                    meas_width[l*5 +: 5] = 5'(w);
                    if (m_st[l] != 2) m_avg[l] = (m_avg[l] * (m_k - 1) + 1000 * w) / m_k;
                end
                meas_ack = 1; m_meas++;
                if (m_k == 3) begin m_k = 1; model_step(); end
                else m_k++;
            end
        end
    end

    // PHY register responder and per-write checks (R2, R3, R6..R10).
    initial begin
        forever begin
            @(negedge clk);
            phy_rvalid = 0;
            if (phy_wr) begin
                int l;
                l = int'(phy_lane);
                chk(m_act[l] == 1, "R10 write only to lane active this iteration", l, -1);
                chk(phy_wdata[15:4] == regs[l][15:4], "R3 upper bits kept",
                    int'(phy_wdata[15:4]), int'(regs[l][15:4]));
                chk(int'(phy_wdata[3:0]) == code_of(m_wr[l]),
                    (m_iter == 0) ? "R2 initial code" : "R6/R7/R8/R9 step code",
                    int'(phy_wdata[3:0]), code_of(m_wr[l]));
                regs[l] = phy_wdata; m_wcnt[l]++;
            end
            if (phy_rd) begin
                repeat (1 + $urandom % 3) @(negedge clk);
                phy_rdata  = regs[int'(phy_lane)];
                phy_rvalid = 1;
            end
        end
    end

    task automatic run_case(input int md, input int pk);
        int tmo;
        mode = md;
        for (int l = 0; l < LANES; l++) begin
            int p;
            case (pk)
                1: p = 13 + int'($urandom % 50);
                2: p = (l == 0) ? 12 : (l == 1) ? 13 : int'($urandom % 13);
                default: p = int'($urandom % 21);
            endcase
            prior_win[l*8 +: 8] = 8'(p);
            regs[l] = 16'($urandom); regs0[l] = regs[l];
            m_st[l] = (p > 12) ? 2 : 0; m_avg[l] = 0; m_best[l] = 0; m_cur[l] = 0;
            m_lim[l] = 0; m_last[l] = 0; m_wr[l] = 0;
            m_act[l] = (p > 12) ? 0 : 1; m_wexp[l] = (p > 12) ? 0 : 1; m_wcnt[l] = 0;
        end
        m_k = 1; m_cnt = 0; m_iter = 0; m_meas = 0;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        chk(done == 0, "R11 done low after start", int'(done), 0);
        tmo = 0;
        while (!done && tmo < 20000) begin @(negedge clk); tmo++; end
        chk(tmo < 20000, "R10 run completes (watchdog)", tmo, 0);
        chk(m_iter == MAXIT, "R10 iteration count", m_iter, MAXIT);
        chk(m_meas == 3 * MAXIT, "R4 three measurements per iteration", m_meas, 3 * MAXIT);
        for (int l = 0; l < LANES; l++) begin
            chk(int'(final_idx[l*3 +: 3]) == m_wr[l], "R11 final index",
                int'(final_idx[l*3 +: 3]), m_wr[l]);
            chk(m_wcnt[l] == m_wexp[l], "R1 R10 writes per lane", m_wcnt[l], m_wexp[l]);
            if (m_wexp[l] == 0)
                chk(regs[l] == regs0[l], "R1 settled lane untouched", int'(regs[l]), int'(regs0[l]));
            else
                chk(int'(regs[l][3:0]) == code_of(m_wr[l]), "R3 final register code",
                    int'(regs[l][3:0]), code_of(m_wr[l]));
        end
        repeat (3) @(negedge clk);
        chk(done == 1, "R11 done held", int'(done), 1);
    endtask

    initial begin
        void'($urandom(32'd2718));
        repeat (4) @(negedge clk);
        chk(done == 0 && meas_req == 0 && phy_rd == 0 && phy_wr == 0,
            "R12 reset outputs idle", int'({done, meas_req, phy_rd, phy_wr}), 0);
        rst_n = 1;
        @(negedge clk);
        chk(done == 0, "R11 no done before start", int'(done), 0);
        run_case(1, 0);   // steady climb to 7
        run_case(2, 2);   // falling window, threshold 12/13
        run_case(3, 0);   // near-margin values
        run_case(0, 1);   // every lane settled at start
        for (int r = 0; r < 6; r++) run_case(0, (r % 2 == 0) ? 0 : 2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule